// File: doc/BRIEF.md
# Ethernet MAC run-control handshake

This block is the run-control register logic of a simple Ethernet MAC. Software writes a small control word to start the MAC, to stop it, or to put it through a soft reset. The stop and reset requests are reported back as busy bits that the hardware clears when the operation has actually finished, so software polls them. A separate enable bit shows whether the MAC is running. A fourth bit chooses whether the MAC talks to the internal PHY or to an external one. The block drives an enable and a soft-reset line to the transmit and receive datapaths. It takes a frame-idle input from them and will not report a stop or reset as complete until the datapaths sit at a frame boundary.

The logic is a four-state machine. OFF is stopped. RUN is running. DRAIN means a stop is pending and the block waits for frame idle. RESET means a soft reset is in progress. These are the transitions:
- OFF to RUN on an enable write.
- OFF or RUN to DRAIN on a disable write.
- DRAIN to OFF when frame idle is sampled high.
- Any state other than RESET to RESET on a reset write.
- RESET to OFF once the reset window has expired and frame idle is high.

Control-word layout: bit 0 enable, bit 1 disable, bit 2 soft reset, bit 3 PHY select (0 internal, 1 external). Reads return the same positions.

Top module: `mac_ctl_top`

## Requirements
- R1: After reset, the control readback is all zero, and mac_en and mac_rst are low.
- R2: In OFF, a write with bit 0 set and bits 1 and 2 clear sets readback bit 0 and mac_en from the next cycle.
- R3: A write with bit 1 set and bit 2 clear, made in OFF or RUN, clears readback bit 0 and mac_en and sets readback bit 1 from the next cycle. Bit 1 clears one cycle after frame_idle is first sampled high following that write, so with frame_idle held high it reads 1 for exactly one cycle.
- R4: While a disable is pending, readback bit 1 stays at 1 for as long as frame_idle stays low.
- R5: A write with bit 0 set that arrives while a disable is pending has no effect. After the disable completes, readback bit 0 and mac_en are 0.
- R6: A write with bit 2 set starts a soft reset. Readback bit 2 and mac_rst are then 1 for exactly RST_CYCLES cycles (default 8) when frame_idle is high. Afterwards readback bits 0, 1 and 2 are 0.
- R7: Readback bit 3 and phy_ext take bit 3 of every write that has bit 2 clear and is made outside a soft reset. A reset write leaves them unchanged.
- R8: Writes made during a soft reset are ignored: they change neither the PHY select nor the state after the reset.
- R9: If frame_idle is low when the reset window expires, the soft reset continues until frame_idle is high.
- R10: A write with bits 0 and 1 both set is treated as a disable.
- R11: In RUN, a write with bits 0, 1 and 2 all clear leaves readback bit 0 and mac_en at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control-word write strobe, one cycle per write |
| wr_data | input | REG_W | Control word to write |
| frame_idle | input | 1 | High when the datapaths sit at a frame boundary |
| rd_data | output | REG_W | Control readback: enable, disable busy, reset busy, PHY select |
| mac_en | output | 1 | Run enable to the datapaths |
| mac_rst | output | 1 | Soft reset to the datapaths |
| phy_ext | output | 1 | 1 selects the external PHY path |

## Verification
The bench targets the points where a handshake like this usually goes wrong.

- It holds frame_idle low during a pending stop. A design that cleared the busy bit without waiting would return to OFF early.
- It sends an enable into that pending stop. A design that latched the enable would restart the MAC after the stop completed.
- It counts the reset window cycle by cycle and stretches it with frame_idle low. It also writes during the reset, where a leaky decode would change the PHY select or re-enable the MAC.
- It sends words that carry enable and disable together. A wrong priority would leave the MAC running.

// File: rtl/mac_ctl_pkg.sv
package mac_ctl_pkg;
    localparam int BIT_EN  = 0;
    localparam int BIT_DIS = 1;
    localparam int BIT_RST = 2;
    localparam int BIT_PHY = 3;
    localparam int MIN_W   = 4;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_RUN,
        ST_DRAIN,
        ST_RESET
    } ctl_state_t;
endpackage

// File: rtl/mac_ctl_cmd.sv
module mac_ctl_cmd
    import mac_ctl_pkg::*;
#(
    parameter int REG_W = 4
) (
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic             req_en,
    output logic             req_dis,
    output logic             req_rst,
    output logic             phy_we,
    output logic             phy_val
);
    // Reset outranks disable, and disable outranks enable.
    always_comb begin
        req_rst = wr_en & wr_data[BIT_RST];
        req_dis = wr_en & ~wr_data[BIT_RST] & wr_data[BIT_DIS];
        req_en  = wr_en & ~wr_data[BIT_RST] & ~wr_data[BIT_DIS] & wr_data[BIT_EN];
        phy_we  = wr_en & ~wr_data[BIT_RST];
        phy_val = wr_data[BIT_PHY];
    end
endmodule

// File: rtl/mac_ctl_timer.sv
module mac_ctl_timer #(
    parameter int RST_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic expired
);
    localparam int CW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
    localparam logic [CW-1:0] LOAD = CW'(RST_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= LOAD;
        else if (run && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/mac_ctl_fsm.sv
module mac_ctl_fsm
    import mac_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_en,
    input  logic req_dis,
    input  logic req_rst,
    input  logic phy_we,
    input  logic phy_val,
    input  logic frame_idle,
    input  logic tmr_expired,
    output logic tmr_start,
    output logic tmr_run,
    output logic en_bit,
    output logic dis_bit,
    output logic rst_bit,
    output logic phy_bit
);
    ctl_state_t st, st_nx;

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_OFF: begin
                if (req_rst)      st_nx = ST_RESET;
                else if (req_dis) st_nx = ST_DRAIN;
                else if (req_en)  st_nx = ST_RUN;
            end
            ST_RUN: begin
                if (req_rst)      st_nx = ST_RESET;
                else if (req_dis) st_nx = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (req_rst)         st_nx = ST_RESET;
                else if (frame_idle) st_nx = ST_OFF;
            end
            ST_RESET: begin
                if (tmr_expired && frame_idle) st_nx = ST_OFF;
            end
            default: st_nx = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= ST_OFF;
            phy_bit <= 1'b0;
        end else begin
            st <= st_nx;
            if (phy_we && st != ST_RESET)
                phy_bit <= phy_val;
        end
    end

    always_comb begin
        en_bit    = (st == ST_RUN);
        dis_bit   = (st == ST_DRAIN);
        rst_bit   = (st == ST_RESET);
        tmr_run   = (st == ST_RESET);
        tmr_start = (st != ST_RESET) && (st_nx == ST_RESET);
    end

    // R3
    drain_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dis_bit) && !rst_bit |-> $past(frame_idle));

    // R9
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_bit) |-> $past(frame_idle) && $past(tmr_expired));
endmodule

// File: rtl/mac_ctl_top.sv
module mac_ctl_top
    import mac_ctl_pkg::*;
#(
    parameter int REG_W      = 4,
    parameter int RST_CYCLES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             frame_idle,
    output logic [REG_W-1:0] rd_data,
    output logic             mac_en,
    output logic             mac_rst,
    output logic             phy_ext
);
    logic req_en, req_dis, req_rst, phy_we, phy_val;
    logic tmr_start, tmr_run, tmr_expired;
    logic en_bit, dis_bit, rst_bit, phy_bit;

    mac_ctl_cmd #(.REG_W(REG_W)) u_cmd (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .req_en  (req_en),
        .req_dis (req_dis),
        .req_rst (req_rst),
        .phy_we  (phy_we),
        .phy_val (phy_val)
    );

    mac_ctl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_en      (req_en),
        .req_dis     (req_dis),
        .req_rst     (req_rst),
        .phy_we      (phy_we),
        .phy_val     (phy_val),
        .frame_idle  (frame_idle),
        .tmr_expired (tmr_expired),
        .tmr_start   (tmr_start),
        .tmr_run     (tmr_run),
        .en_bit      (en_bit),
        .dis_bit     (dis_bit),
        .rst_bit     (rst_bit),
        .phy_bit     (phy_bit)
    );

    mac_ctl_timer #(.RST_CYCLES(RST_CYCLES)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .run     (tmr_run),
        .expired (tmr_expired)
    );

    always_comb begin
        rd_data          = '0;
        rd_data[BIT_EN]  = en_bit;
        rd_data[BIT_DIS] = dis_bit;
        rd_data[BIT_RST] = rst_bit;
        rd_data[BIT_PHY] = phy_bit;
    end

    assign mac_en  = en_bit;
    assign mac_rst = rst_bit;
    assign phy_ext = phy_bit;

    // Independent count of how long each soft reset has lasted.
    logic [31:0] rst_len;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rst_len <= '0;
        else if (mac_rst)
            rst_len <= rst_len + 1;
        else
            rst_len <= '0;
    end

    initial begin
        width_chk: assert (REG_W >= MIN_W);
    end

    // R6
    reset_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mac_rst) |-> $past(rst_len) >= RST_CYCLES - 1);

    // R6
    status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_data[BIT_RST:BIT_EN]));

    // R5
    enable_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mac_en) |-> !$past(rd_data[BIT_DIS]) && !$past(mac_rst));

    // R7
    phy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mac_rst && $past(mac_rst) |-> $stable(phy_ext));
endmodule

// File: tb/sim_mac_ctl_top.sv
`timescale 1ns/1ps
module sim_mac_ctl_top;
    localparam int REG_W = 4;
    localparam int RST_CYCLES = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [REG_W-1:0] wr_data = '0;
    logic frame_idle = 1'b1;
    logic [REG_W-1:0] rd_data;
    logic mac_en, mac_rst, phy_ext;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    mac_ctl_top #(.REG_W(REG_W), .RST_CYCLES(RST_CYCLES)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .frame_idle(frame_idle), .rd_data(rd_data), .mac_en(mac_en),
        .mac_rst(mac_rst), .phy_ext(phy_ext)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [REG_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    task automatic go_off();
        frame_idle = 1'b1;
        wr(4'b0010);
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        chk("R1 rd_data", int'(rd_data), 0);
        chk("R1 mac_en", int'(mac_en), 0);
        chk("R1 mac_rst", int'(mac_rst), 0);
    endtask

    task automatic t_enable();
        wr(4'b0001);
        chk("R2 enable bit", int'(rd_data[0]), 1);
        chk("R2 mac_en", int'(mac_en), 1);
    endtask

    task automatic t_run_zero_write();
        wr(4'b0000);
        chk("R11 enable held", int'(rd_data[0]), 1);
        chk("R11 mac_en held", int'(mac_en), 1);
    endtask

    task automatic t_disable_fast();
        int hi;
        frame_idle = 1'b1;
        wr(4'b0010);
        chk("R3 enable cleared", int'(rd_data[0]), 0);
        chk("R3 mac_en cleared", int'(mac_en), 0);
        hi = 0;
        for (int i = 0; i < 10; i++) begin
            if (rd_data[1]) hi++;
            @(negedge clk);
        end
        chk("R3 disable busy cycles", hi, 1);
    endtask

    task automatic t_disable_slow();
        wr(4'b0001);
        frame_idle = 1'b0;
        wr(4'b0010);
        repeat (5) @(negedge clk);
        chk("R4 disable held while busy", int'(rd_data[1]), 1);
        wr(4'b0001);
        chk("R5 enable ignored in drain", int'(mac_en), 0);
        frame_idle = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R3 disable cleared after idle", int'(rd_data[1]), 0);
        chk("R5 enable after drain", int'(rd_data[0]), 0);
        chk("R5 mac_en after drain", int'(mac_en), 0);
    endtask

    task automatic t_both_bits();
        wr(4'b0001);
        wr(4'b0011);
        chk("R10 disable wins enable", int'(mac_en), 0);
        chk("R10 disable busy", int'(rd_data[1]), 1);
        @(negedge clk);
        wr(4'b0011);
        @(negedge clk);
        chk("R10 from off stays off", int'(rd_data[0]), 0);
    endtask

    task automatic t_phy_select();
        wr(4'b1000);
        chk("R7 phy external", int'(phy_ext), 1);
        chk("R7 phy readback", int'(rd_data[3]), 1);
        wr(4'b0001);
        chk("R7 phy internal", int'(phy_ext), 0);
        go_off();
    endtask

    task automatic t_reset_len();
        int hi;
        frame_idle = 1'b1;
        wr(4'b0001);
        wr(4'b0100);
        hi = 0;
        for (int i = 0; i < 20; i++) begin
            if (rd_data[2]) hi++;
            @(negedge clk);
        end
        chk("R6 reset busy cycles", hi, RST_CYCLES);
        chk("R6 enable after reset", int'(rd_data[0]), 0);
        chk("R6 disable after reset", int'(rd_data[1]), 0);
        chk("R6 mac_rst after reset", int'(mac_rst), 0);
    endtask

    task automatic t_reset_writes();
        wr(4'b1001);
        wr(4'b0100);
        chk("R7 phy kept by reset write", int'(phy_ext), 1);
        chk("R6 mac_rst during reset", int'(mac_rst), 1);
        wr(4'b0001);
        wr(4'b0000);
        repeat (RST_CYCLES + 4) @(negedge clk);
        chk("R8 phy after reset writes", int'(phy_ext), 1);
        chk("R8 enable after reset writes", int'(mac_en), 0);
        chk("R8 reset finished", int'(rd_data[2]), 0);
    endtask

    task automatic t_reset_idle_hold();
        frame_idle = 1'b0;
        wr(4'b0100);
        repeat (RST_CYCLES + 4) @(negedge clk);
        chk("R9 reset held while busy", int'(rd_data[2]), 1);
        frame_idle = 1'b1;
        @(negedge clk);
        chk("R9 reset done after idle", int'(rd_data[2]), 0);
    endtask

    initial begin
        #(4 * 20000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_enable();
        t_run_zero_write();
        t_disable_fast();
        t_disable_slow();
        t_both_bits();
        t_phy_select();
        t_reset_len();
        t_reset_writes();
        t_reset_idle_hold();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule